// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR flash that runs in 16-bit word mode, and it runs the erase commands for that flash. A requester asks for one of two erases. A chip erase clears the whole array. A sector erase clears one sector and takes a sector address with the request. The block then drives the flash address, write data, chip enable, write enable and output enable through a six-write command sequence. Every setup, strobe, hold and cycle length is a whole number of clocks set by a parameter.

After the final command write, the block waits for the embedded erase to finish. The requester chooses how this wait is done for each request:

- **Ready/busy pin:** the block watches the flash's active-low ready/busy pin.
- **Status polling:** the block reads the status word repeatedly.

When the wait ends, the block returns a single-cycle `done` or `err` pulse. It takes no new request until that pulse.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, chip enable, write enable and output enable are high, the data bus is not driven, `req_ready` is high, and `done` and `err` are low.
- R2: An accepted request produces exactly six write strobes. The first five carry address/data 555h/00AAh, 2AAh/0055h, 555h/0080h, 555h/00AAh and 2AAh/0055h, in that order.
- R3: For a chip erase (`req_sector`=0), the sixth write is address 555h with data 0010h.
- R4: For a sector erase (`req_sector`=1), the sixth write is address `req_addr` with data 0030h.
- R5: Write enable stays low for exactly T_WP clocks.
  - The address is already valid on the clock before write enable falls.
  - The address and data do not change while write enable is low.
  - The address and data are still unchanged on the first clock after write enable rises.
- R6: Output enable is high whenever write enable is low.
- R7: In ready/busy mode (`req_poll`=0), `done` pulses for exactly one clock. The pulse comes only after the busy pin has been seen low and has returned high.
- R8: In polling mode (`req_poll`=1), the block reads with output enable low and the bus released. It pulses `done` when bit 7 of the read word is 1.
- R9: In polling mode, `err` pulses when bit 5 has already been seen as 1 and a later read shows bit 7 still at 0.
- R10: In ready/busy mode, `err` pulses if the busy pin is still low TIMEOUT clocks after the wait began.
- R11: While a sequence or its wait is in progress, `req_ready` is low and `req_valid` has no effect: no extra write strobe follows.
- R12: Within one sequence, successive falling edges of write enable are exactly max(T_WC, T_AS+T_WP+T_WPH) clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request strobe, taken when `req_ready` is high |
| req_sector | input | 1 | 1 selects sector erase, 0 selects chip erase |
| req_poll | input | 1 | 1 waits by status polling, 0 waits on the ready/busy pin |
| req_addr | input | AW | Sector address; also the address used for status reads |
| req_ready | output | 1 | Idle, so a request can be taken |
| done | output | 1 | One-clock pulse: erase finished |
| err | output | 1 | One-clock pulse: erase failed or timed out |
| flash_a | output | AW | Flash word address |
| flash_dq_o | output | 16 | Write data to the flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_o` |
| flash_dq_i | input | 16 | Read data from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_busy_n | input | 1 | Ready/busy pin, low while the flash is busy |

## Verification
The bench runs both erase types against a flash model. The model logs every write strobe and drops its busy pin shortly after the sixth write. A chip erase and a sector erase set apart the two possible final cycles. Running each with ready/busy waiting and with polling exercises both wait paths. Short and long busy times show whether a poll loop ends on its first read or keeps rereading.

Two failure patterns cover the error paths:

- A status word stuck with bit 5 set while busy must lead to `err` in polling mode.
- A busy pin that never rises must lead to `err` in ready/busy mode, and only after the timeout.

A second `req_valid` pulse is also issued part-way through a sequence. This shows whether requests are truly ignored while busy, or whether they leak extra writes onto the bus.

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int AW      = 24,
  parameter int T_AS    = 2,
  parameter int T_WP    = 3,
  parameter int T_WPH   = 2,
  parameter int T_WC    = 8,
  parameter int T_BUSY  = 6,
  parameter int T_ACC   = 3,
  parameter int T_GAP   = 2,
  parameter int TIMEOUT = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_sector,
  input  logic          req_poll,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] flash_a,
  output logic [15:0]   flash_dq_o,
  output logic          flash_dq_oe,
  input  logic [15:0]   flash_dq_i,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  input  logic          flash_busy_n
);

  localparam int HOLD = (T_WC - T_AS - T_WP > T_WPH) ? (T_WC - T_AS - T_WP) : T_WPH;
  localparam int M1 = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int M2 = (M1 > HOLD) ? M1 : HOLD;
  localparam int M3 = (M2 > T_BUSY) ? M2 : T_BUSY;
  localparam int M4 = (M3 > T_ACC) ? M3 : T_ACC;
  localparam int M5 = (M4 > T_GAP) ? M4 : T_GAP;
  localparam int CW = $clog2(M5 + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WSET, S_WLOW, S_WHOLD, S_BDLY, S_WRDY, S_RACC, S_RGAP
  } st_t;

  st_t           state;
  logic [2:0]    step;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic          is_sec, use_poll, dq5_seen;
  logic [AW-1:0] sa;
  logic          busy_s1, busy_s2;

  wire tmo_hit  = tmo >= TW'(TIMEOUT - 1);
  wire cnt_zero = cnt == '0;

  assign req_ready = state == S_IDLE;

  function automatic logic [AW+15:0] cmd(input logic [2:0] s, input logic sec,
                                         input logic [AW-1:0] addr);
    case (s)
      3'd0, 3'd3: cmd = {AW'(11'h555), 16'h00AA};
      3'd1, 3'd4: cmd = {AW'(11'h2AA), 16'h0055};
      3'd2:       cmd = {AW'(11'h555), 16'h0080};
      default:    cmd = sec ? {addr, 16'h0030} : {AW'(11'h555), 16'h0010};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_s1 <= 1'b1;
      busy_s2 <= 1'b1;
    end else begin
      busy_s1 <= flash_busy_n;
      busy_s2 <= busy_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= '0;
      cnt         <= '0;
      tmo         <= '0;
      is_sec      <= 1'b0;
      use_poll    <= 1'b0;
      dq5_seen    <= 1'b0;
      sa          <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      flash_a     <= '0;
      flash_dq_o  <= '0;
      flash_dq_oe <= 1'b0;
      flash_ce_n  <= 1'b1;
      flash_we_n  <= 1'b1;
      flash_oe_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          is_sec      <= req_sector;
          use_poll    <= req_poll;
          sa          <= req_addr;
          step        <= '0;
          {flash_a, flash_dq_o} <= cmd(3'd0, req_sector, req_addr);
          flash_ce_n  <= 1'b0;
          flash_dq_oe <= 1'b1;
          cnt         <= CW'(T_AS - 1);
          state       <= S_WSET;
        end
        S_WSET: if (cnt_zero) begin
          flash_we_n <= 1'b0;
          cnt        <= CW'(T_WP - 1);
          state      <= S_WLOW;
        end else cnt <= cnt - 1'b1;
        S_WLOW: if (cnt_zero) begin
          flash_we_n <= 1'b1;
          cnt        <= CW'(HOLD - 1);
          state      <= S_WHOLD;
        end else cnt <= cnt - 1'b1;
        S_WHOLD: if (cnt_zero) begin
          if (step == 3'd5) begin
            flash_ce_n  <= 1'b1;
            flash_dq_oe <= 1'b0;
            tmo         <= '0;
            dq5_seen    <= 1'b0;
            cnt         <= CW'(T_BUSY - 1);
            state       <= S_BDLY;
          end else begin
            step  <= step + 3'd1;
            {flash_a, flash_dq_o} <= cmd(step + 3'd1, is_sec, sa);
            cnt   <= CW'(T_AS - 1);
            state <= S_WSET;
          end
        end else cnt <= cnt - 1'b1;
        S_BDLY: if (cnt_zero) begin
          if (use_poll) begin
            flash_a    <= sa;
            flash_ce_n <= 1'b0;
            flash_oe_n <= 1'b0;
            cnt        <= CW'(T_ACC - 1);
            state      <= S_RACC;
          end else state <= S_WRDY;
        end else cnt <= cnt - 1'b1;
        S_WRDY: begin
          if (!tmo_hit) tmo <= tmo + 1'b1;
          if (busy_s2) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (tmo_hit) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_RACC: begin
          if (!tmo_hit) tmo <= tmo + 1'b1;
          if (cnt_zero) begin
            flash_ce_n <= 1'b1;
            flash_oe_n <= 1'b1;
            if (flash_dq_i[7]) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else if (tmo_hit || (flash_dq_i[5] && dq5_seen)) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              dq5_seen <= dq5_seen | flash_dq_i[5];
              cnt      <= CW'(T_GAP - 1);
              state    <= S_RGAP;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_RGAP: begin
          if (!tmo_hit) tmo <= tmo + 1'b1;
          if (cnt_zero) begin
            flash_ce_n <= 1'b0;
            flash_oe_n <= 1'b0;
            cnt        <= CW'(T_ACC - 1);
            state      <= S_RACC;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> flash_oe_n);

  a_r5_bus_stable_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_a) && $stable(flash_dq_o)));

  a_r5_we_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> !flash_ce_n);

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> !flash_dq_oe);

  a_r7_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_ce_n |-> !req_ready);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));

endmodule

// File: tb/nor_erase_seq_tb.sv
module nor_erase_seq_tb;
  localparam int AW = 24;
  localparam int T_AS = 2, T_WP = 3, T_WPH = 2, T_WC = 8;
  localparam int TIMEOUT = 400;
  localparam int PER = (T_WC > T_AS + T_WP + T_WPH) ? T_WC : (T_AS + T_WP + T_WPH);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_sector = 0, req_poll = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, done, err;
  logic [AW-1:0] flash_a;
  logic [15:0] flash_dq_o, flash_dq_i;
  logic flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;
  logic flash_busy_n;

  always #2 clk = ~clk;

  nor_erase_seq #(.AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_WC(T_WC),
                  .T_BUSY(6), .T_ACC(3), .T_GAP(2), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sector(req_sector),
    .req_poll(req_poll), .req_addr(req_addr), .req_ready(req_ready), .done(done),
    .err(err), .flash_a(flash_a), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
    .flash_dq_i(flash_dq_i), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n), .flash_busy_n(flash_busy_n));

  int checks = 0, errors = 0;
  logic [AW-1:0] qa[$];
  logic [15:0]   qd[$];
  string         qt[$];
  bit            qe[$];
  string         qrt[$];

  int  m_len = 0;
  bit  m_fail = 0;
  int  clr_seq = 0, clr_seen = 0;
  bit  mbusy = 0;
  int  mdly = 0, mleft = 0;
  bit  saw_busy = 0;
  int  nreads = 0, nwr = 0, since_fall = 0, lowcnt = 0, since_last = 0;
  logic [AW-1:0] fall_a, prev_a;
  logic [15:0]   fall_d;
  bit prev_we = 1, prev_oe = 1, prev_res = 0;

  assign flash_busy_n = !mbusy;
  assign flash_dq_i = mbusy ? (m_fail ? 16'h0020 : 16'h0000) : 16'hFFFF;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (clr_seq != clr_seen) begin
      clr_seen = clr_seq;
      mbusy = 0; mdly = 0;
    end
    if (prev_we && !flash_we_n) begin
      chk(flash_oe_n, "R6", "oe_n at we fall", flash_oe_n, 1);
      chk(prev_a == flash_a, "R5", "addr setup before we fall", flash_a, prev_a);
      if (nwr % 6 != 0) chk(since_fall == PER, "R12", "we fall spacing", since_fall, PER);
      else begin saw_busy = 0; nreads = 0; end
      fall_a = flash_a; fall_d = flash_dq_o; lowcnt = 1; since_fall = 0;
    end else if (!flash_we_n) lowcnt++;
    if (!prev_we && flash_we_n) begin
      chk(lowcnt == T_WP, "R5", "we low width", lowcnt, T_WP);
      chk(flash_a == fall_a && flash_dq_o == fall_d, "R5", "addr/data held past we rise",
          {flash_a, flash_dq_o}, {fall_a, fall_d});
      if (qa.size() == 0) chk(0, "R11", "unexpected write", {flash_a, flash_dq_o}, 0);
      else begin
        logic [AW-1:0] ea; logic [15:0] ed; string et;
        ea = qa.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
        chk(flash_a == ea && flash_dq_o == ed, et, "write addr/data",
            {flash_a, flash_dq_o}, {ea, ed});
      end
      nwr++;
      since_last = 0;
      if (nwr % 6 == 0) mdly = 2;
    end
    if (mdly > 0) begin
      mdly--;
      if (mdly == 0) begin mbusy = 1; mleft = m_len; end
    end else if (mbusy && !m_fail) begin
      if (mleft == 0) mbusy = 0; else mleft--;
    end
    if (mbusy) saw_busy = 1;
    if (prev_oe && !flash_oe_n) nreads++;
    if (done || err) begin
      chk(!prev_res, "R7", "result pulse longer than one clock", 1, 0);
      if (qe.size() == 0) chk(0, "R11", "unexpected result", err, 0);
      else begin
        bit ee; string rt;
        ee = qe.pop_front(); rt = qrt.pop_front();
        chk(err == ee && done == !ee, rt, "result err", err, ee);
        if (rt == "R7") chk(saw_busy && flash_busy_n, rt, "done after busy low then high",
                             {saw_busy, flash_busy_n}, 2'b11);
        if (rt == "R7" || rt == "R10") chk(nreads == 0, rt, "no reads in pin mode", nreads, 0);
        if (rt == "R8") chk(nreads >= 1, rt, "status reads", nreads, 1);
        if (rt == "R9") chk(nreads == 2, rt, "reads before error", nreads, 2);
        if (rt == "R10") chk(since_last >= TIMEOUT, rt, "timeout wait", since_last, TIMEOUT);
      end
    end
    prev_res = done || err;
    prev_we = flash_we_n; prev_oe = flash_oe_n; prev_a = flash_a;
    since_fall++; since_last++;
  end

  task automatic run(input bit sec, input logic [AW-1:0] sa, input bit poll,
                     input int len, input bit fail, input bit poke);
    qa.push_back(24'h555); qd.push_back(16'h00AA); qt.push_back("R2");
    qa.push_back(24'h2AA); qd.push_back(16'h0055); qt.push_back("R2");
    qa.push_back(24'h555); qd.push_back(16'h0080); qt.push_back("R2");
    qa.push_back(24'h555); qd.push_back(16'h00AA); qt.push_back("R2");
    qa.push_back(24'h2AA); qd.push_back(16'h0055); qt.push_back("R2");
    if (sec) begin qa.push_back(sa); qd.push_back(16'h0030); qt.push_back("R4"); end
    else begin qa.push_back(24'h555); qd.push_back(16'h0010); qt.push_back("R3"); end
    qe.push_back(fail);
    qrt.push_back(poll ? (fail ? "R9" : "R8") : (fail ? "R10" : "R7"));
    m_len = len; m_fail = fail;
    while (!req_ready) @(negedge clk);
    req_sector = sec; req_poll = poll; req_addr = sa; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (30) @(negedge clk);
      chk(!req_ready, "R11", "ready low mid-sequence", req_ready, 0);
      req_sector = !sec; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      repeat (40) @(negedge clk);
      chk(!req_ready, "R11", "ready low during wait", req_ready, 0);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (qe.size() != 0) @(negedge clk);
    chk(qa.size() == 0, "R2", "all six writes seen", qa.size(), 0);
    if (fail) begin clr_seq++; m_fail = 0; end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_ce_n && flash_we_n && flash_oe_n, "R1", "strobes in reset",
        {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
    rst_n = 1;
    @(negedge clk);
    chk(flash_ce_n && flash_we_n && flash_oe_n, "R1", "strobes after reset",
        {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
    chk(!flash_dq_oe, "R1", "bus released", flash_dq_oe, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    chk(!done && !err, "R1", "no result after reset", {done, err}, 0);
    run(0, 24'h000000, 0, 25, 0, 0);
    run(1, 24'h3A0000, 0, 60, 0, 1);
    run(0, 24'h000000, 1, 40, 0, 0);
    run(1, 24'h123450, 1, 0, 0, 0);
    run(1, 24'h7F8000, 1, 10, 1, 0);
    run(0, 24'h000000, 0, 10, 1, 0);
    run(1, 24'hFFFFFF, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule